// File: doc/BRIEF.md
# Bus Node Discovery Controller

This block runs the join procedure that lets one slave node announce itself on a shared serial bus that has a separate, wired, open-drain detection line. After power-on reset, or whenever a connect event is signalled, the node clears its bus address, waits a pseudo-random number of prescaled ticks and then pulls the detection line. The master answers with an address assignment; on success the node keeps the address, lets the detection line go and raises a one-cycle request for its descriptor records to be sent.

The master can instead report a failed assignment, typically because two nodes claimed the line at once. The node then drops the line and starts over with the next pseudo-random delay. If the master stays silent for too long, the node handles it the same way. When the back-off ends while another node already holds the detection line, the node waits for the line to go free before pulling it. This avoids stacking a second request on one already in progress.

Top module: `node_join_ctrl`

## Requirements
- R1: While reset is high, node_id_o is 0, id_valid_o is 0, det_drive_o is 0 and desc_req_o is 0; the join procedure begins when reset is released.
- R2: A connect_i pulse in any state clears node_id_o and id_valid_o on the next edge, releases the detection line and restarts the join procedure.
- R3: The delay comes from a 16-bit right-shifting Galois LFSR with tap mask 0xB400, loaded from seed_i during reset (a zero seed loads 1) and stepped once per procedure start. With d the low DLY_BITS bits of the stepped value, det_drive_o rises exactly 1 + (d+1)*TICK_DIV clock edges after the edge that samples the trigger (the connect pulse or the failing strobe), or after the first edge with reset low.
- R4: If det_sense_i is high when the delay ends, det_drive_o stays low until det_sense_i is seen low, and then rises on the next edge.
- R5: A strobe with asg_err_i low while det_drive_o is high loads asg_addr_i (4 bits) into node_id_o and sets id_valid_o. On the same edge it drops det_drive_o and raises desc_req_o for exactly one cycle.
- R6: A strobe with asg_err_i high while det_drive_o is high drops det_drive_o, leaves id_valid_o low and restarts the procedure with the next LFSR value.
- R7: If no strobe arrives for TIMEOUT_TICKS*TICK_DIV edges after det_drive_o rises, det_drive_o drops and the procedure restarts with the next LFSR value.
- R8: Strobes that arrive while det_drive_o is low are ignored: the address and valid flag keep their values and the pending delay is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| connect_i | input | 1 | One-cycle pulse when the node is (re)connected |
| seed_i | input | 16 | Per-node LFSR seed, sampled in reset |
| det_drive_o | output | 1 | 1 pulls the open-drain detection line active |
| det_sense_i | input | 1 | Observed detection line level, 1 = active |
| asg_stb_i | input | 1 | Address-assignment strobe from the master |
| asg_err_i | input | 1 | Assignment failed (collision), valid with the strobe |
| asg_addr_i | input | 4 | Assigned address, valid with the strobe |
| node_id_o | output | 4 | Held node address |
| id_valid_o | output | 1 | node_id_o holds an assigned address |
| desc_req_o | output | 1 | One-cycle request to send descriptor records |

## Verification
The bench builds the block with TICK_DIV=4, DLY_BITS=3 and TIMEOUT_TICKS=6. Every back-off then lasts at most 33 edges and a silent master times out after 24. A short run therefore goes through many join rounds and reaches all eight delay codes. Collisions, timeouts, deferral behind a busy line and strobes outside the claim window are each forced directly, and rounds with random addresses and random collision outcomes are mixed in.

// File: rtl/node_join_pkg.sv
package node_join_pkg;

    localparam int NODE_ADDR_W = 4;
    localparam int SEED_W      = 16;
    localparam logic [SEED_W-1:0] SEED_TAPS = 16'hB400;

    typedef enum logic [2:0] {
        ST_START,
        ST_BACKOFF,
        ST_DEFER,
        ST_CLAIM,
        ST_JOINED
    } join_state_e;

    typedef struct packed {
        logic                   err;
        logic [NODE_ADDR_W-1:0] addr;
    } assign_msg_t;

endpackage

// File: rtl/node_join_lfsr.sv
module node_join_lfsr #(
    parameter int             W     = 16,
    parameter logic [W-1:0]   TAPS  = 16'hB400,
    parameter int             OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     seed_i,
    input  logic             step_i,
    output logic [OUT_W-1:0] next_low_o
);
    logic [W-1:0] q;
    logic [W-1:0] nxt;

    always_comb begin
        nxt = {1'b0, q[W-1:1]} ^ (q[0] ? TAPS : '0);
    end

    assign next_low_o = nxt[OUT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= (seed_i == '0) ? W'(1) : seed_i;
        end else if (step_i) begin
            q <= nxt;
        end
    end

    p_lfsr_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        q != '0);
endmodule

// File: rtl/node_join_timer.sv
module node_join_timer #(
    parameter int DIV   = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);
    localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

    logic             armed;
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] cnt;

    assign expire_o = armed && (pre == PRE_LAST) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            pre   <= '0;
            cnt   <= '0;
        end else if (load_i) begin
            armed <= 1'b1;
            pre   <= '0;
            cnt   <= load_val_i;
        end else if (armed) begin
            if (pre == PRE_LAST) begin
                pre <= '0;
                if (cnt == '0) armed <= 1'b0;
                else           cnt   <= cnt - CNT_W'(1);
            end else begin
                pre <= pre + PRE_W'(1);
            end
        end
    end

    // a fresh load never expires on the following cycle unless one tick is one cycle
    p_load_restarts_r3: assert property (@(posedge clk) disable iff (rst)
        (load_i && DIV > 1) |=> !expire_o);
endmodule

// File: rtl/node_join_ctrl.sv
module node_join_ctrl
    import node_join_pkg::*;
#(
    parameter int TICK_DIV      = 1000,
    parameter int DLY_BITS      = 4,
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   connect_i,
    input  logic [SEED_W-1:0]      seed_i,
    output logic                   det_drive_o,
    input  logic                   det_sense_i,
    input  logic                   asg_stb_i,
    input  logic                   asg_err_i,
    input  logic [NODE_ADDR_W-1:0] asg_addr_i,
    output logic [NODE_ADDR_W-1:0] node_id_o,
    output logic                   id_valid_o,
    output logic                   desc_req_o
);
    localparam int TO_W  = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
    localparam int CNT_W = (DLY_BITS > TO_W) ? DLY_BITS : TO_W;
    localparam logic [CNT_W-1:0] TO_LOAD = CNT_W'(TIMEOUT_TICKS - 1);

    join_state_e          state_q, state_d;
    assign_msg_t          msg;
    logic                 lfsr_step;
    logic [DLY_BITS-1:0]  dly_code;
    logic                 tmr_load;
    logic [CNT_W-1:0]     tmr_val;
    logic                 tmr_expire;
    logic                 take;

    assign msg = '{err: asg_err_i, addr: asg_addr_i};

    node_join_lfsr #(
        .W     (SEED_W),
        .TAPS  (SEED_TAPS),
        .OUT_W (DLY_BITS)
    ) lfsr_i (
        .clk        (clk),
        .rst        (rst),
        .seed_i     (seed_i),
        .step_i     (lfsr_step),
        .next_low_o (dly_code)
    );

    node_join_timer #(
        .DIV   (TICK_DIV),
        .CNT_W (CNT_W)
    ) timer_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expire_o   (tmr_expire)
    );

    always_comb begin
        state_d   = state_q;
        lfsr_step = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        take      = 1'b0;
        unique case (state_q)
            ST_START: begin
                lfsr_step = 1'b1;
                tmr_load  = 1'b1;
                tmr_val   = CNT_W'(dly_code);
                state_d   = ST_BACKOFF;
            end
            ST_BACKOFF: begin
                if (tmr_expire) begin
                    if (det_sense_i) begin
                        state_d = ST_DEFER;
                    end else begin
                        state_d  = ST_CLAIM;
                        tmr_load = 1'b1;
                        tmr_val  = TO_LOAD;
                    end
                end
            end
            ST_DEFER: begin
                if (!det_sense_i) begin
                    state_d  = ST_CLAIM;
                    tmr_load = 1'b1;
                    tmr_val  = TO_LOAD;
                end
            end
            ST_CLAIM: begin
                if (asg_stb_i) begin
                    if (msg.err) begin
                        state_d = ST_START;
                    end else begin
                        take    = 1'b1;
                        state_d = ST_JOINED;
                    end
                end else if (tmr_expire) begin
                    state_d = ST_START;
                end
            end
            ST_JOINED: ;
            default: state_d = ST_START;
        endcase
        if (connect_i) begin
            state_d   = ST_START;
            lfsr_step = 1'b0;
            tmr_load  = 1'b0;
            take      = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_START;
            node_id_o  <= '0;
            id_valid_o <= 1'b0;
            desc_req_o <= 1'b0;
        end else begin
            state_q    <= state_d;
            desc_req_o <= take;
            if (connect_i) begin
                node_id_o  <= '0;
                id_valid_o <= 1'b0;
            end else if (take) begin
                node_id_o  <= msg.addr;
                id_valid_o <= 1'b1;
            end
        end
    end

    assign det_drive_o = (state_q == ST_CLAIM);

    p_connect_clears_r2: assert property (@(posedge clk) disable iff (rst)
        connect_i |=> (!id_valid_o && node_id_o == '0 && !det_drive_o));

    p_claim_only_free_line_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(det_drive_o) |-> $past(!det_sense_i));

    p_desc_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        desc_req_o |=> !desc_req_o);

    p_desc_after_accept_r5: assert property (@(posedge clk) disable iff (rst)
        desc_req_o |-> (id_valid_o && !det_drive_o));

    p_no_claim_when_joined_r5: assert property (@(posedge clk) disable iff (rst)
        id_valid_o |-> !det_drive_o);

    p_err_no_address_r6: assert property (@(posedge clk) disable iff (rst)
        (det_drive_o && asg_stb_i && asg_err_i) |=> (!id_valid_o && !det_drive_o));

    p_joined_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (id_valid_o && !connect_i) |=> (id_valid_o && $stable(node_id_o)));

    p_idle_strobe_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (!det_drive_o && !id_valid_o && !connect_i) |=> !id_valid_o);
endmodule

// File: tb/node_join_ctrl_tb_top.sv
`timescale 1ns/1ps
module node_join_ctrl_tb_top;
    localparam int DIV = 4;
    localparam int DLY = 3;
    localparam int TOT = 6;
    localparam logic [15:0] SEED = 16'hACE1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       connect = 1'b0;
    logic       other = 1'b0;
    logic       stb = 1'b0;
    logic       err = 1'b0;
    logic [3:0] addr = '0;
    logic       drive;
    logic       sense;
    logic [3:0] node_id;
    logic       valid;
    logic       desc;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [15:0] m_lfsr = SEED;

    always #5 clk = ~clk;

    assign sense = drive | other;

    node_join_ctrl #(
        .TICK_DIV      (DIV),
        .DLY_BITS      (DLY),
        .TIMEOUT_TICKS (TOT)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .connect_i   (connect),
        .seed_i      (SEED),
        .det_drive_o (drive),
        .det_sense_i (sense),
        .asg_stb_i   (stb),
        .asg_err_i   (err),
        .asg_addr_i  (addr),
        .node_id_o   (node_id),
        .id_valid_o  (valid),
        .desc_req_o  (desc)
    );

    function automatic logic [15:0] lstep(input logic [15:0] s);
        return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    // edges from the current negedge until the line must be driven (R3)
    function int next_wait();
        m_lfsr = lstep(m_lfsr);
        return 1 + (int'(m_lfsr[DLY-1:0]) + 1) * DIV;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_claim(input int n, input string req);
        repeat (n - 1) @(negedge clk);
        chk(drive == 1'b0, req, "line before delay end", int'(drive), 0);
        @(negedge clk);
        chk(drive == 1'b1, req, "line at delay end", int'(drive), 1);
    endtask

    task automatic pulse_connect();
        connect = 1'b1;
        @(negedge clk);
        connect = 1'b0;
    endtask

    task automatic do_assign(input logic [3:0] a);
        stb = 1'b1; err = 1'b0; addr = a;
        @(negedge clk);
        stb = 1'b0;
        chk(node_id == a, "R5", "address latched", int'(node_id), int'(a));
        chk(valid == 1'b1, "R5", "valid set", int'(valid), 1);
        chk(desc == 1'b1, "R5", "descriptor request", int'(desc), 1);
        chk(drive == 1'b0, "R5", "line released", int'(drive), 0);
        @(negedge clk);
        chk(desc == 1'b0, "R5", "request lasts one cycle", int'(desc), 0);
    endtask

    task automatic collide();
        stb = 1'b1; err = 1'b1; addr = 4'hF;
        @(negedge clk);
        stb = 1'b0; err = 1'b0;
        chk(drive == 1'b0, "R6", "line dropped on collision", int'(drive), 0);
        chk(valid == 1'b0, "R6", "no address on collision", int'(valid), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(node_id == 4'd0, "R1", "reset id", int'(node_id), 0);
        chk(valid == 1'b0, "R1", "reset valid", int'(valid), 0);
        chk(drive == 1'b0, "R1", "reset line", int'(drive), 0);
        chk(desc == 1'b0, "R1", "reset request", int'(desc), 0);
        rst = 1'b0;
        expect_claim(next_wait(), "R3");
        do_assign(4'd5);

        // strobe while joined is ignored (R8)
        stb = 1'b1; addr = 4'd9;
        @(negedge clk);
        stb = 1'b0;
        @(negedge clk);
        chk(node_id == 4'd5, "R8", "joined id kept", int'(node_id), 5);
        chk(valid == 1'b1, "R8", "joined valid kept", int'(valid), 1);

        // reconnect clears the address (R2)
        pulse_connect();
        chk(valid == 1'b0, "R2", "valid cleared", int'(valid), 0);
        chk(node_id == 4'd0, "R2", "id cleared", int'(node_id), 0);
        expect_claim(next_wait(), "R2");

        // collision restarts with fresh delay (R6)
        collide();
        expect_claim(next_wait(), "R6");

        // silent master times out (R7)
        repeat (TOT * DIV - 1) @(negedge clk);
        chk(drive == 1'b1, "R7", "line held before timeout", int'(drive), 1);
        @(negedge clk);
        chk(drive == 1'b0, "R7", "line dropped at timeout", int'(drive), 0);
        chk(valid == 1'b0, "R7", "no address after timeout", int'(valid), 0);
        expect_claim(next_wait(), "R7");
        do_assign(4'd12);

        // strobe during back-off is ignored, timing unchanged (R8)
        begin
            int n;
            pulse_connect();
            n = next_wait();
            stb = 1'b1; err = 1'b0; addr = 4'd3;
            @(negedge clk);
            stb = 1'b0;
            chk(valid == 1'b0, "R8", "back-off strobe ignored", int'(valid), 0);
            expect_claim(n - 1, "R8");
        end
        do_assign(4'd0);

        // busy line defers the claim (R4)
        begin
            int n;
            pulse_connect();
            other = 1'b1;
            n = next_wait();
            repeat (n) @(negedge clk);
            chk(drive == 1'b0, "R4", "no claim while line busy", int'(drive), 0);
            repeat (5) @(negedge clk);
            chk(drive == 1'b0, "R4", "still deferred", int'(drive), 0);
            other = 1'b0;
            @(negedge clk);
            chk(drive == 1'b1, "R4", "claim once line free", int'(drive), 1);
        end
        do_assign(4'd15);

        // random rounds
        for (int i = 0; i < 10; i++) begin
            logic [3:0] a;
            pulse_connect();
            chk(valid == 1'b0, "R2", "random reconnect clears", int'(valid), 0);
            expect_claim(next_wait(), "R3");
            while (($urandom % 3) == 0) begin
                collide();
                expect_claim(next_wait(), "R6");
            end
            a = 4'($urandom % 16);
            do_assign(a);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule